// File: doc/BRIEF.md
# Synchronized Dual-Carrier Modulator

This block combines one modulation data bit with two carrier waveforms. While the data bit is 1 the output tracks a "high" carrier. While it is 0 the output tracks a "low" carrier. Each carrier is chosen from a vector of ten candidate inputs by a 4-bit code held in a 16-bit control word. Each carrier can be inverted. Each carrier's pin-drive signal can be switched off.

Either carrier can also be synchronized. A synchronized carrier stays in use after the data bit asks to leave it, until that carrier shows a falling edge. Falling edges are detected on the system clock, on the carrier after inversion. This keeps clipped pulses and glitches off the output when the data bit changes partway through a carrier period.

The control word is split into two bytes. Bits 15:8 hold the high-carrier fields:
- bit 15: disable
- bit 14: invert
- bit 13: sync
- bits 11:8: select

Bits 7:0 hold the same fields for the low carrier in the same positions: bit 7 disable, bit 6 invert, bit 5 sync, bits 3:0 select. Bits 12 and 4 are unused.

Top module: `carrier_modulator`

## Requirements
- R1: High-carrier select code 0 yields constant 0. A code k from 1 to 10 yields `cand_in[k-1]`. Index 0 and 1 are the two external carrier inputs, index 2 is the reference clock and indices 3..9 are compare/PWM outputs 1..7.
- R2: A select code from 11 to 15 gives a carrier that reads as 0 before inversion, for either carrier.
- R3: The low-carrier select field (bits 3:0) uses the same code map as the high-carrier field (bits 11:8).
- R4: With the invert bit set (bit 14 high carrier, bit 6 low carrier), the selected carrier is complemented before it is used for the output or for edge detection.
- R5: An active-carrier flag starts at low after reset. When the data bit differs from the flag and the current carrier's sync bit is clear, the flag takes the data value at the next clock edge. The output `mod_out` equals the inverted-if-selected carrier picked by the flag.
- R6: When the high-carrier sync bit (bit 13) is set and the high carrier is in use, a change to the low carrier happens only at the clock edge where the registered high carrier is 1 and the current high carrier is 0.
- R7: When the low-carrier sync bit (bit 5) is set and the low carrier is in use, a change to the high carrier happens only at a clock edge where a falling edge of the low carrier is seen in the same way.
- R8: `hi_pin_drv` is the inverted-if-selected high carrier, forced to 0 while bit 15 is set. `lo_pin_drv` is the same for the low carrier, gated by bit 7.
- R9: `ctrl_rd` returns the control word with bits 12 and 4 read as 0.
- R10: While `rst_n` is low, `mod_out` is 0 whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_word | input | 16 | Control word (fields as above) |
| cand_in | input | 10 | Candidate carrier sources, index = code-1 |
| data_bit | input | 1 | Modulation data |
| mod_out | output | 1 | Modulated output |
| hi_pin_drv | output | 1 | High-carrier pin-drive signal |
| lo_pin_drv | output | 1 | Low-carrier pin-drive signal |
| ctrl_rd | output | 16 | Control word read back |

## Verification
The hardest case is a pending switch: the data bit has already changed, but the old carrier must stay on the output because no falling edge has appeared. The stimulus holds the old carrier at 1 and the other carrier at 0 for several clock edges after the data bit flips. A premature switch would therefore show at the output. Both carriers are then changed on the same cycle, so that the falling edge and the switch can be seen together at one clock edge.

// File: rtl/carrier_modulator.sv
module carrier_modulator #(
  parameter int SEL_W   = 4,
  parameter int NUM_SRC = 10,
  parameter int CTRL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [NUM_SRC-1:0] cand_in,
  input  logic              data_bit,
  output logic              mod_out,
  output logic              hi_pin_drv,
  output logic              lo_pin_drv,
  output logic [CTRL_W-1:0] ctrl_rd
);
  localparam int HALF = CTRL_W / 2;
  localparam int DIS  = HALF - 1;
  localparam int POL  = HALF - 2;
  localparam int SYN  = HALF - 3;
  localparam logic [CTRL_W-1:0] RD_MASK =
    ~((CTRL_W'(1) << (HALF + SEL_W)) | (CTRL_W'(1) << SEL_W));

  function automatic logic pick(input logic [SEL_W-1:0] sel, input logic [NUM_SRC-1:0] src);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (int'(sel) == i + 1) r = src[i];
    return r;
  endfunction

  logic [HALF-1:0] hi_f, lo_f;
  logic hi_adj, lo_adj, hi_q, lo_q, act_q, hi_fall, lo_fall, may_switch;

  assign hi_f = ctrl_word[CTRL_W-1:HALF];
  assign lo_f = ctrl_word[HALF-1:0];

  assign hi_adj  = pick(hi_f[SEL_W-1:0], cand_in) ^ hi_f[POL];
  assign lo_adj  = pick(lo_f[SEL_W-1:0], cand_in) ^ lo_f[POL];
  assign hi_fall = hi_q & ~hi_adj;
  assign lo_fall = lo_q & ~lo_adj;

  assign may_switch = act_q ? (~hi_f[SYN] | hi_fall) : (~lo_f[SYN] | lo_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      hi_q <= hi_adj;
      lo_q <= lo_adj;
      if ((data_bit != act_q) && may_switch) act_q <= data_bit;
    end
  end

  assign mod_out    = rst_n & (act_q ? hi_adj : lo_adj);
  assign hi_pin_drv = hi_adj & ~hi_f[DIS];
  assign lo_pin_drv = lo_adj & ~lo_f[DIS];
  assign ctrl_rd    = ctrl_word & RD_MASK;
endmodule

// File: rtl/carrier_modulator_chk.sv
module carrier_modulator_chk #(
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              data_bit,
  input logic              mod_out,
  input logic              hi_pin_drv,
  input logic              lo_pin_drv,
  input logic              act_q,
  input logic              hi_q,
  input logic              lo_q,
  input logic              hi_adj,
  input logic              lo_adj
);
  localparam int HALF = CTRL_W / 2;

  // R10
  always @(negedge clk)
    if (!rst_n) reset_out_chk: assert (!mod_out);

  // R5
  nosync_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !ctrl_word[HALF-3] && data_bit) |=> act_q);

  // R6
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ctrl_word[CTRL_W-3] && !(hi_q && !hi_adj)) |=> act_q);

  // R7
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && ctrl_word[HALF-3] && !(lo_q && !lo_adj)) |=> !act_q);

  // R8
  hi_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[CTRL_W-1] |-> !hi_pin_drv);

  // R8
  lo_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[HALF-1] |-> !lo_pin_drv);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ctrl_word[CTRL_W-5 -: 4] >= 4'd11 && !ctrl_word[CTRL_W-2]) |-> !mod_out);
endmodule

bind carrier_modulator carrier_modulator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .data_bit(data_bit),
  .mod_out(mod_out), .hi_pin_drv(hi_pin_drv), .lo_pin_drv(lo_pin_drv),
  .act_q(act_q), .hi_q(hi_q), .lo_q(lo_q), .hi_adj(hi_adj), .lo_adj(lo_adj)
);

// File: tb/sim_carrier_modulator.sv
module sim_carrier_modulator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic [9:0]  cand_in = '0;
  logic data_bit = 1'b0;
  logic mod_out, hi_pin_drv, lo_pin_drv;
  logic [15:0] ctrl_rd;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  carrier_modulator u0 (.clk, .rst_n, .ctrl_word, .cand_in, .data_bit,
                        .mod_out, .hi_pin_drv, .lo_pin_drv, .ctrl_rd);

  // {ctrl, cand, data, expected out, requirement}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {16'h0001, 10'b0000000001, 1'b0, 1'b1, 4'd3},  // R3 code 1
    {16'h0000, 10'b1111111111, 1'b0, 1'b0, 4'd3},  // R3 code 0
    {16'h0003, 10'b0000000100, 1'b0, 1'b1, 4'd3},  // R3 code 3
    {16'h000A, 10'b1000000000, 1'b0, 1'b1, 4'd3},  // R3 code 10
    {16'h000A, 10'b0111111111, 1'b0, 1'b0, 4'd3},  // R3 code 10 neg
    {16'h000B, 10'b1111111111, 1'b0, 1'b0, 4'd2},  // R2
    {16'h000F, 10'b1111111111, 1'b0, 1'b0, 4'd2},  // R2
    {16'h0200, 10'b0000000010, 1'b1, 1'b1, 4'd1},  // R1 code 2
    {16'h0200, 10'b1111111101, 1'b1, 1'b0, 4'd1},  // R1 code 2 neg
    {16'h0C00, 10'b1111111111, 1'b1, 1'b0, 4'd2},  // R2 high
    {16'h4700, 10'b0001000000, 1'b1, 1'b0, 4'd4},  // R4 high invert
    {16'h4000, 10'b0000000000, 1'b1, 1'b1, 4'd4},  // R4 high invert code 0
    {16'h0041, 10'b0000000000, 1'b0, 1'b1, 4'd4}   // R4 low invert
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R10 output held at 0 under reset
    ctrl_word = 16'h0001; cand_in = '1;
    edges(2);
    chk("R10 reset out", 16'(mod_out), 16'h0);
    @(negedge clk) rst_n = 1'b1;
    edges(1);
    chk("R5 low after reset", 16'(mod_out), 16'h1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ctrl_word = VEC[i][31:16]; cand_in = VEC[i][15:6]; data_bit = VEC[i][5];
      edges(2);
      chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), 16'(mod_out), 16'(VEC[i][4]));
    end

    // R6 high sync: hi=cand[0], lo=cand[1]
    @(negedge clk);
    ctrl_word = 16'h2102; cand_in = 10'b0000000001; data_bit = 1'b1;
    edges(2);
    chk("R6 on high", 16'(mod_out), 16'h1);
    @(negedge clk) data_bit = 1'b0;
    edges(3);
    chk("R6 held on high", 16'(mod_out), 16'h1);
    @(negedge clk) cand_in = 10'b0000000010;
    edges(1);
    chk("R6 switch at fall", 16'(mod_out), 16'h1);

    // R7 low sync
    @(negedge clk);
    ctrl_word = 16'h0122; cand_in = 10'b0000000010; data_bit = 1'b1;
    edges(3);
    chk("R7 held on low", 16'(mod_out), 16'h1);
    @(negedge clk) cand_in = 10'b0000000001;
    edges(1);
    chk("R7 switch at fall", 16'(mod_out), 16'h1);

    // R5 immediate switch without sync
    @(negedge clk);
    ctrl_word = 16'h0102; cand_in = 10'b0000000001; data_bit = 1'b0;
    edges(1);
    chk("R5 immediate switch", 16'(mod_out), 16'h0);

    // R8 pin drive gating
    @(negedge clk);
    ctrl_word = 16'h8101; cand_in = 10'b0000000001;
    edges(1);
    chk("R8 hi disabled", 16'(hi_pin_drv), 16'h0);
    chk("R8 lo enabled", 16'(lo_pin_drv), 16'h1);
    @(negedge clk) ctrl_word = 16'h0181;
    edges(1);
    chk("R8 hi enabled", 16'(hi_pin_drv), 16'h1);
    chk("R8 lo disabled", 16'(lo_pin_drv), 16'h0);

    // R9 readback
    @(negedge clk) ctrl_word = 16'hFFFF;
    edges(1);
    chk("R9 readback", ctrl_rd, 16'hEFEF);

    finish_run();
  end
endmodule